// File: doc/BRIEF.md
# PHY Configuration Register Bank with Per-Bit Write Mask

This block holds the control settings of a storage-interface PHY in seven 32-bit words and reports two PHY status flags in an eighth, read-only word. Each control word keeps 16 live bits. On a write, bits 31:16 of the bus data form a per-bit enable for bits 15:0. A lower bit is stored only when its matching upper bit is set, so software can change one field without reading the word first.

The stored bits feed the PHY control pins directly. These are the power-enable bit, the DLL enable, the DLL frequency code, the driver impedance code, and the output tap-delay enable and select. The two status inputs are calibration complete and DLL locked. They come from the PHY's own clock domain, so they pass through a parameterised flop synchronizer before they can be read. The bus port has no wait states: a write takes effect on the clock edge that samples it, and read data is a combinational function of the address.

Top module: `phycfg_bank`

## Requirements
- R1: On a write to a control word, stored bit x takes data bit x when data bit x+16 is 1 and keeps its old value when data bit x+16 is 0. The new value is visible from the next clock edge.
- R2: A read of a control word returns the stored 16 bits in bits 15:0 and zero in bits 31:16.
- R3: After reset every control bit is 0. The PHY is therefore powered down, the DLL is disabled, and every control field output is 0.
- R4: The word at byte offset 0x18 drives the power-enable output from bit 0, the DLL-enable output from bit 1 and the 3-bit impedance code from bits 6:4. The codes are 0=50 ohm, 1=33 ohm, 2=66 ohm, 3=100 ohm and 4=40 ohm.
- R5: The word at byte offset 0x00 drives the 2-bit DLL frequency code from bits 13:12, the tap-delay enable from bit 11 and the 4-bit tap-delay select from bits 10:7. The frequency codes are 0=200 MHz, 1=50 MHz, 2=100 MHz and 3=150 MHz.
- R6: A read of byte offset 0x20 returns the calibration-complete flag in bit 5+1=6 and the DLL-locked flag in bit 5, with all other bits 0. A change on either status input shows up there after SYNC_STAGES clock edges.
- R7: A write to 0x20, to an aligned offset above 0x18 that is not 0x20, or to any offset whose low two bits are not 00 changes no control word.
- R8: A read of any offset other than the seven control words and 0x20 returns zero. This includes offsets whose low two bits are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Byte address of the access |
| cfg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cfg_wdata | input | 32 | Write data: bits 31:16 are the mask, bits 15:0 the value |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| cal_done_i | input | 1 | PHY calibration complete, asynchronous |
| dll_ready_i | input | 1 | PHY DLL locked, asynchronous |
| phy_pwr_on | output | 1 | PHY power enable (1 = powered) |
| phy_dll_en | output | 1 | DLL enable |
| phy_dll_freq | output | 2 | DLL frequency code |
| phy_drive | output | 3 | Driver impedance code |
| phy_tap_en | output | 1 | Output tap-delay enable |
| phy_tap_sel | output | 4 | Output tap-delay select |

## Verification
The masked write is driven with random masks over every control word. Full masks, empty masks and single-bit masks are mixed in, so each bit's write enable is tested separately from the value bit it guards. A full mask shows whether the value bits arrive at all. An empty mask shows whether a write with no enables still disturbs the word. A single-bit mask placed on one field of the PHY words shows whether the neighbouring fields, and the pins they drive, hold their values. The random addresses include the status offset, the gap above the last control word, misaligned offsets and arbitrary bytes, so stray writes and stray reads are told apart from mapped accesses. The status flags are stepped through all four combinations.

// File: rtl/phycfg_pkg.sv
`timescale 1ns/1ps
package phycfg_pkg;
   // word indices (byte offset / 4) whose fields reach the PHY pins
   localparam int PHY_WORD_IDX   = 6;     // byte offset 0x18
   localparam int TIMING_WORD_IDX = 0;    // byte offset 0x00
   localparam int STATUS_BYTE_OFF = 'h20;

   // field positions in the PHY word
   localparam int B_PWR     = 0;
   localparam int B_DLL_EN  = 1;
   localparam int DRV_LSB   = 4;
   localparam int DRV_W     = 3;

   // field positions in the timing word
   localparam int TAP_LSB   = 7;
   localparam int TAP_W     = 4;
   localparam int B_TAP_EN  = 11;
   localparam int FRQ_LSB   = 12;
   localparam int FRQ_W     = 2;

   // status word bit positions
   localparam int ST_DLL    = 5;
   localparam int ST_CAL    = 6;

   typedef enum logic [DRV_W-1:0] {
      IMP_50 = 3'd0, IMP_33 = 3'd1, IMP_66 = 3'd2, IMP_100 = 3'd3, IMP_40 = 3'd4
   } impedance_e;

   typedef enum logic [FRQ_W-1:0] {
      DLLF_200 = 2'd0, DLLF_50 = 2'd1, DLLF_100 = 2'd2, DLLF_150 = 2'd3
   } dll_freq_e;
endpackage

// File: rtl/phycfg_mreg.sv
`timescale 1ns/1ps
module phycfg_mreg #(
   parameter int HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2*HALF_W-1:0]   wr_data,
   output logic [HALF_W-1:0]     q
);
   logic [HALF_W-1:0] mask_w;
   logic [HALF_W-1:0] val_w;

   assign mask_w = wr_data[2*HALF_W-1:HALF_W];
   assign val_w  = wr_data[HALF_W-1:0];

   // one enabled flop per bit: the mask bit is the flop's own enable
   for (genvar b = 0; b < HALF_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[b] <= 1'b0;
         else if (wr_en && mask_w[b])
            q[b] <= val_w[b];
      end
   end

   // R1: unmasked bits keep their value
   p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & ~$past(mask_w)) == ($past(q) & ~$past(mask_w))));
   // R1: masked bits take the write value
   p_mask_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & $past(mask_w)) == ($past(val_w) & $past(mask_w))));
   // R1: no write, no change
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/phycfg_sync.sv
`timescale 1ns/1ps
module phycfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st <= '0;
         else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++)
               st[k] <= st[k-1];
         end
      end

      assign q = st[STAGES-1];

      // R6: each stage delays by exactly one edge
      p_first_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
         st[0] == $past(d));
      for (genvar k = 1; k < STAGES; k++) begin : g_chk
         p_stage_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            st[k] == $past(st[k-1]));
      end
   end
endmodule

// File: rtl/phycfg_decode.sv
`timescale 1ns/1ps
module phycfg_decode #(
   parameter int ADDR_W     = 8,
   parameter int HALF_W     = 16,
   parameter int NUM_CTRL   = 7,
   parameter int STATUS_OFF = 'h20
) (
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [NUM_CTRL-1:0][HALF_W-1:0]   ctrl_q,
   input  logic [HALF_W-1:0]                 status_word,
   output logic [NUM_CTRL-1:0]               ctrl_sel,
   output logic                              ctrl_hit,
   output logic [2*HALF_W-1:0]               rdata
);
   localparam int IDX_W = ADDR_W - 2;

   logic              aligned;
   logic [IDX_W-1:0]  idx;
   logic              status_hit;

   assign aligned    = (addr[1:0] == 2'b00);
   assign idx        = addr[ADDR_W-1:2];
   assign status_hit = (addr == ADDR_W'(STATUS_OFF));

   always_comb begin
      for (int r = 0; r < NUM_CTRL; r++)
         ctrl_sel[r] = aligned && (idx == IDX_W'(r));
   end

   assign ctrl_hit = |ctrl_sel;

   always_comb begin
      rdata = '0;
      if (status_hit)
         rdata = {{HALF_W{1'b0}}, status_word};
      for (int r = 0; r < NUM_CTRL; r++)
         if (ctrl_sel[r])
            rdata = {{HALF_W{1'b0}}, ctrl_q[r]};
   end

   // R7: at most one control word is selected by any address
   always_comb begin
      a_sel_onehot_r7: assert ($onehot0(ctrl_sel));
   end
endmodule

// File: rtl/phycfg_bank.sv
`timescale 1ns/1ps
module phycfg_bank #(
   parameter int ADDR_W      = 8,
   parameter int HALF_W      = 16,
   parameter int NUM_CTRL    = 7,
   parameter int STATUS_OFF  = phycfg_pkg::STATUS_BYTE_OFF,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic                  cfg_wr,
   input  logic [2*HALF_W-1:0]   cfg_wdata,
   output logic [2*HALF_W-1:0]   cfg_rdata,
   input  logic                  cal_done_i,
   input  logic                  dll_ready_i,
   output logic                  phy_pwr_on,
   output logic                  phy_dll_en,
   output logic [1:0]            phy_dll_freq,
   output logic [2:0]            phy_drive,
   output logic                  phy_tap_en,
   output logic [3:0]            phy_tap_sel
);
   import phycfg_pkg::*;

   localparam int DATA_W   = 2 * HALF_W;
   localparam int PHY_OFF  = PHY_WORD_IDX * 4;
   localparam int TIM_OFF  = TIMING_WORD_IDX * 4;

   // elaboration-time parameter checks
   if (HALF_W < FRQ_LSB + FRQ_W) begin : g_bad_width
      $error("phycfg_bank: HALF_W too small for the field map");
   end
   if (NUM_CTRL <= PHY_WORD_IDX) begin : g_bad_count
      $error("phycfg_bank: NUM_CTRL must cover the PHY word");
   end
   if (STATUS_OFF < NUM_CTRL * 4 || STATUS_OFF % 4 != 0 || STATUS_OFF >= (1 << ADDR_W)) begin : g_bad_status
      $error("phycfg_bank: STATUS_OFF overlaps, is misaligned or out of range");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("phycfg_bank: SYNC_STAGES out of range");
   end

   logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q;
   logic [NUM_CTRL-1:0]             ctrl_sel;
   logic                            ctrl_hit;
   logic [HALF_W-1:0]               status_word;
   logic [1:0]                      flags_sync;

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_word
      phycfg_mreg #(.HALF_W(HALF_W)) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_wr && ctrl_sel[r]),
         .wr_data (cfg_wdata),
         .q       (ctrl_q[r])
      );
   end

   phycfg_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cal_done_i, dll_ready_i}),
      .q     (flags_sync)
   );

   always_comb begin
      status_word         = '0;
      status_word[ST_CAL] = flags_sync[1];
      status_word[ST_DLL] = flags_sync[0];
   end

   phycfg_decode #(
      .ADDR_W     (ADDR_W),
      .HALF_W     (HALF_W),
      .NUM_CTRL   (NUM_CTRL),
      .STATUS_OFF (STATUS_OFF)
   ) u_decode (
      .addr        (cfg_addr),
      .ctrl_q      (ctrl_q),
      .status_word (status_word),
      .ctrl_sel    (ctrl_sel),
      .ctrl_hit    (ctrl_hit),
      .rdata       (cfg_rdata)
   );

   // field fan-out to the PHY pins
   assign phy_pwr_on   = ctrl_q[PHY_WORD_IDX][B_PWR];
   assign phy_dll_en   = ctrl_q[PHY_WORD_IDX][B_DLL_EN];
   assign phy_drive    = ctrl_q[PHY_WORD_IDX][DRV_LSB +: DRV_W];
   assign phy_tap_sel  = ctrl_q[TIMING_WORD_IDX][TAP_LSB +: TAP_W];
   assign phy_tap_en   = ctrl_q[TIMING_WORD_IDX][B_TAP_EN];
   assign phy_dll_freq = ctrl_q[TIMING_WORD_IDX][FRQ_LSB +: FRQ_W];

   // R7: nothing but a mapped control write changes the words
   p_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && ctrl_hit) |=> $stable(ctrl_q));
   // R4: an enabled write of the power bit reaches the pin next edge
   p_pwr_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == ADDR_W'(PHY_OFF) && cfg_wdata[HALF_W + B_PWR])
      |=> (phy_pwr_on == $past(cfg_wdata[B_PWR])));
   // R5: a fully enabled frequency write reaches the pins next edge
   p_freq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == ADDR_W'(TIM_OFF) && (&cfg_wdata[HALF_W + FRQ_LSB +: FRQ_W]))
      |=> (phy_dll_freq == $past(cfg_wdata[FRQ_LSB +: FRQ_W])));
   // R2: the upper half of any read is zero
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[DATA_W-1:HALF_W] == '0);
endmodule

// File: tb/phycfg_bank_bench.sv
`timescale 1ns/1ps
module phycfg_bank_bench;
   localparam int NWORDS = 7;
   localparam int SYNC   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cal_done_i = 1'b0;
   logic        dll_ready_i = 1'b0;
   logic        phy_pwr_on, phy_dll_en, phy_tap_en;
   logic [1:0]  phy_dll_freq;
   logic [2:0]  phy_drive;
   logic [3:0]  phy_tap_sel;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [15:0] model [NWORDS];

   always #10 clk = ~clk;

   phycfg_bank #(.SYNC_STAGES(SYNC)) u_phycfg_bank (
      .clk, .rst_n, .cfg_addr, .cfg_wr, .cfg_wdata, .cfg_rdata,
      .cal_done_i, .dll_ready_i, .phy_pwr_on, .phy_dll_en,
      .phy_dll_freq, .phy_drive, .phy_tap_en, .phy_tap_sel
   );

   function automatic bit mapped(input logic [7:0] a);
      return (a[1:0] == 2'b00) && (a[7:2] < NWORDS);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      if (mapped(a)) return {16'h0, model[a[7:2]]};
      if (a == 8'h20) return {25'h0, cal_done_i, dll_ready_i, 5'h0};
      return 32'h0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (mapped(a))
         model[a[7:2]] = (model[a[7:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
   endtask

   task automatic read_check(input string req, input logic [7:0] a);
      cfg_addr = a;
      #1;
      check(req, cfg_rdata, exp_read(a));
   endtask

   task automatic pins_check();
      check("R4 pwr", {31'h0, phy_pwr_on}, {31'h0, model[6][0]});
      check("R4 dll_en", {31'h0, phy_dll_en}, {31'h0, model[6][1]});
      check("R4 drive", {29'h0, phy_drive}, {29'h0, model[6][6:4]});
      check("R5 tap_sel", {28'h0, phy_tap_sel}, {28'h0, model[0][10:7]});
      check("R5 tap_en", {31'h0, phy_tap_en}, {31'h0, model[0][11]});
      check("R5 freq", {30'h0, phy_dll_freq}, {30'h0, model[0][13:12]});
   endtask

   task automatic all_words_check(input string req);
      for (int r = 0; r < NWORDS; r++) read_check(req, 8'(r * 4));
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int r = 0; r < NWORDS; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset state
      all_words_check("R3 reset word");
      pins_check();
      check("R3 powered down", {30'h0, phy_pwr_on, phy_dll_en}, 32'h0);

      // R1: full mask, empty mask, single-bit masks
      write(8'h04, 32'hFFFF_A5C3);
      read_check("R1 full mask", 8'h04);
      write(8'h04, 32'h0000_0000);
      read_check("R1 empty mask", 8'h04);
      write(8'h04, 32'h0001_0000);
      read_check("R1 single bit clear", 8'h04);
      check("R1 value", cfg_rdata, 32'h0000_A5C2);

      // R4: PHY word fields one at a time
      write(8'h18, 32'h0001_0001);
      pins_check();
      write(8'h18, 32'h0070_0040);
      pins_check();
      check("R4 drive 40 ohm code", {29'h0, phy_drive}, 32'd4);
      write(8'h18, 32'h0002_0002);
      pins_check();
      check("R4 pwr kept", {31'h0, phy_pwr_on}, 32'h1);

      // R5: timing word fields
      write(8'h00, 32'h0780_0200);
      pins_check();
      write(8'h00, 32'h0800_0800);
      write(8'h00, 32'h3000_3000);
      pins_check();
      check("R5 tap_sel kept", {28'h0, phy_tap_sel}, 32'd4);

      // R7: stray writes
      write(8'h20, 32'hFFFF_FFFF);
      write(8'h1C, 32'hFFFF_FFFF);
      write(8'h01, 32'hFFFF_FFFF);
      write(8'h1A, 32'hFFFF_FFFF);
      write(8'hFC, 32'hFFFF_FFFF);
      all_words_check("R7 stray write");
      pins_check();

      // R8: unmapped reads
      read_check("R8 gap", 8'h1C);
      read_check("R8 misaligned", 8'h05);
      read_check("R8 high", 8'hF0);
      check("R8 misaligned zero", cfg_rdata, 32'h0);

      // R6: status combinations
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         {cal_done_i, dll_ready_i} = 2'(s);
         repeat (SYNC) @(posedge clk);
         @(negedge clk);
         read_check("R6 status", 8'h20);
         read_check("R6 status misaligned", 8'h22);
      end

      // R1/R2/R7/R8: random mix
      for (int i = 0; i < 400; i++) begin
         int k;
         logic [7:0]  a;
         logic [31:0] d;
         k = int'($urandom % 12);
         case (k)
            7:  a = 8'h20;
            8:  a = 8'h1C;
            9:  a = 8'(8'h24 + 4 * ($urandom % 8));
            10: a = 8'(4 * ($urandom % 7) + 1 + $urandom % 3);
            11: a = 8'($urandom);
            default: a = 8'(k * 4);
         endcase
         d = $urandom;
         if ($urandom % 8 == 0) d[31:16] = 16'h0;
         else if ($urandom % 8 == 0) d[31:16] = 16'(1 << ($urandom % 16));
         write(a, d);
         read_check("R1 R2 random readback", a);
         if (i % 25 == 0) begin
            all_words_check("R7 random words");
            pins_check();
         end
      end
      all_words_check("R2 final words");
      pins_check();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule